// File: doc/BRIEF.md
# Multi-Pass Front-to-Back Layer Selector

This block does hidden surface removal for one screen tile of 16 by 32 pixels. All per-pixel depth and coverage state is held in on-chip registers. Fragments stream in, and each one carries a pixel index, a depth, an 8-bit subpixel coverage mask, an opaque flag and a tag. During one pass over the tile's fragment list, each pixel keeps one candidate. The candidate is the nearest fragment that lies strictly behind the depth resolved in the previous pass and still covers at least one subpixel not yet hidden by opaque coverage. When the last fragment of the pass arrives, the block scans every pixel in address order. For each pixel with a candidate it emits the chosen fragment, with a flag that tells the shader whether to load the colour or to composite it under what is already there.

The host replays the same fragment list pass after pass. Because each pass peels off the next layer, shading always sees the layers of a pixel nearest first, whatever order the transparent fragments were submitted in. A pixel drops out once its accumulated opaque coverage is full, or once a pass finds nothing behind its last resolved depth. After each scan the block reports whether another pass is needed. The number of passes therefore follows the depth complexity of the tile, not the number of subpixel samples. Starting a new tile clears all per-pixel state.

Top module: `zpass_select`

## Requirements
- R1: A cycle with `part_start` high clears every pixel's resolved depth, accumulated opaque mask, candidate and finished state. A fragment accepted in that same cycle is judged against the cleared state.
- R2: In a pass, a pixel selects the fragment with the smallest depth value (smaller means nearer) among those strictly greater than its previously resolved depth. A fragment whose depth equals the resolved depth is not selected again.
- R3: When two eligible fragments at a pixel have equal depth, the one that arrived first is kept.
- R4: A fragment is ignored if its mask has no bit outside the pixel's accumulated opaque mask. This includes a mask of zero.
- R5: The scan starts on the cycle after `frag_last` is accepted. It takes one cycle per pixel, in ascending address order, and at most one fragment is emitted per pixel. `pass_done` is a one-cycle pulse in the cycle that carries the last pixel's result.
- R6: `out_under` is 0 for the first fragment emitted at a pixel since the tile started, and 1 for every later one.
- R7: `more_passes`, sampled with `pass_done`, is 1 exactly when at least one pixel emitted a fragment in this pass and its opaque mask is still not all ones.
- R8: A pixel whose 8 subpixels become fully covered by opaque fragments in one pass emits nothing in later passes.
- R9: `busy` is high during the scan. Fragments presented while `busy` is high are ignored.
- R10: Eight opaque layers, each covering a different single subpixel, resolve in exactly eight passes, one layer per pass in depth order.
- R11: `part_start` during a scan aborts it. `busy` falls on the next cycle, and neither `pass_done` nor any further output is produced for the aborted pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| part_start | input | 1 | Clear all per-pixel state for a new tile |
| frag_valid | input | 1 | Fragment present |
| frag_last | input | 1 | This fragment ends the current pass |
| frag_addr | input | 9 | Pixel index within the tile |
| frag_depth | input | 16 | Depth, smaller is nearer |
| frag_mask | input | 8 | Subpixel coverage |
| frag_opaque | input | 1 | Fragment is opaque |
| frag_tag | input | 8 | Identifier carried to the output |
| busy | output | 1 | Scan in progress, input ignored |
| out_valid | output | 1 | Selected fragment present |
| out_addr | output | 9 | Pixel index of the selected fragment |
| out_depth | output | 16 | Depth of the selected fragment |
| out_mask | output | 8 | Coverage of the selected fragment |
| out_opaque | output | 1 | Opaque flag of the selected fragment |
| out_tag | output | 8 | Tag of the selected fragment |
| out_under | output | 1 | 0: load colour, 1: composite under |
| pass_done | output | 1 | Scan finished |
| more_passes | output | 1 | Another pass is needed |

## Verification
Two functions can land on the same clock edge: clearing the tile with `part_start`, and accepting a fragment. The bench provokes this by presenting a fragment together with `part_start` at a pixel whose old resolved depth would otherwise reject it. It then judges the result from the emitted fragment and its load flag. A second collision is a fragment presented while the scan is running. It is provoked at a pixel the scan has not yet reached, and it is judged by its absence from that pass's output and the next pass's output. The tile clear is also asserted in the middle of a scan, and the bench checks that no pass report appears.

// File: rtl/zpass_select.sv
module zpass_select #(
  parameter int PW = 16,
  parameter int PH = 32,
  parameter int DW = 16,
  parameter int MW = 8,
  parameter int TW = 8,
  localparam int NPIX = PW * PH,
  localparam int AW = $clog2(NPIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          part_start,
  input  logic          frag_valid,
  input  logic          frag_last,
  input  logic [AW-1:0] frag_addr,
  input  logic [DW-1:0] frag_depth,
  input  logic [MW-1:0] frag_mask,
  input  logic          frag_opaque,
  input  logic [TW-1:0] frag_tag,
  output logic          busy,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_depth,
  output logic [MW-1:0] out_mask,
  output logic          out_opaque,
  output logic [TW-1:0] out_tag,
  output logic          out_under,
  output logic          pass_done,
  output logic          more_passes
);

  typedef enum logic {S_IDLE, S_SCAN} st_t;
  st_t st_q;
  logic [AW-1:0] idx_q;
  logic          more_acc_q;

  logic [DW-1:0] rd_q  [NPIX];
  logic [DW-1:0] cd_q  [NPIX];
  logic [MW-1:0] cm_q  [NPIX];
  logic          co_q  [NPIX];
  logic [TW-1:0] ct_q  [NPIX];
  logic          hrd_q [NPIX];
  logic          cv_q  [NPIX];
  logic          done_q[NPIX];
  logic          emit_q[NPIX];
  logic [MW-1:0] opq_q [NPIX];

  assign busy = (st_q == S_SCAN);

  wire acc = frag_valid && (st_q == S_IDLE);

  wire          e_done = part_start ? 1'b0 : done_q[frag_addr];
  wire          e_hrd  = part_start ? 1'b0 : hrd_q[frag_addr];
  wire          e_cv   = part_start ? 1'b0 : cv_q[frag_addr];
  wire [MW-1:0] e_opq  = part_start ? '0   : opq_q[frag_addr];

  wire elig = !e_done && (!e_hrd || frag_depth > rd_q[frag_addr])
              && |(frag_mask & ~e_opq);
  wire take = acc && elig && (!e_cv || frag_depth < cd_q[frag_addr]);

  wire          s_cv   = cv_q[idx_q];
  wire [MW-1:0] s_opq  = opq_q[idx_q] | (co_q[idx_q] ? cm_q[idx_q] : '0);
  wire          s_full = &s_opq;
  wire          s_need = s_cv && !s_full;
  wire          s_last = (idx_q == AW'(NPIX - 1));
  wire          scan   = (st_q == S_SCAN) && !part_start;

  always_ff @(posedge clk) begin
    if (take) begin
      cd_q[frag_addr] <= frag_depth;
      cm_q[frag_addr] <= frag_mask;
      co_q[frag_addr] <= frag_opaque;
      ct_q[frag_addr] <= frag_tag;
    end
    if (scan && s_cv) rd_q[idx_q] <= cd_q[idx_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      idx_q       <= '0;
      more_acc_q  <= 1'b0;
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_depth   <= '0;
      out_mask    <= '0;
      out_opaque  <= 1'b0;
      out_tag     <= '0;
      out_under   <= 1'b0;
      pass_done   <= 1'b0;
      more_passes <= 1'b0;
      for (int p = 0; p < NPIX; p++) begin
        hrd_q[p]  <= 1'b0;
        cv_q[p]   <= 1'b0;
        done_q[p] <= 1'b0;
        emit_q[p] <= 1'b0;
        opq_q[p]  <= '0;
      end
    end else begin
      out_valid <= 1'b0;
      pass_done <= 1'b0;
      if (part_start) begin
        st_q <= S_IDLE;
        for (int p = 0; p < NPIX; p++) begin
          hrd_q[p]  <= 1'b0;
          cv_q[p]   <= 1'b0;
          done_q[p] <= 1'b0;
          emit_q[p] <= 1'b0;
          opq_q[p]  <= '0;
        end
      end else if (st_q == S_SCAN) begin
        if (s_cv) begin
          out_valid     <= 1'b1;
          out_addr      <= idx_q;
          out_depth     <= cd_q[idx_q];
          out_mask      <= cm_q[idx_q];
          out_opaque    <= co_q[idx_q];
          out_tag       <= ct_q[idx_q];
          out_under     <= emit_q[idx_q];
          hrd_q[idx_q]  <= 1'b1;
          opq_q[idx_q]  <= s_opq;
          emit_q[idx_q] <= 1'b1;
          cv_q[idx_q]   <= 1'b0;
          if (s_full) done_q[idx_q] <= 1'b1;
        end else begin
          done_q[idx_q] <= 1'b1;
        end
        more_acc_q <= more_acc_q | s_need;
        if (s_last) begin
          st_q        <= S_IDLE;
          pass_done   <= 1'b1;
          more_passes <= more_acc_q | s_need;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
      if (take) cv_q[frag_addr] <= 1'b1;
      if (acc && frag_last) begin
        st_q       <= S_SCAN;
        idx_q      <= '0;
        more_acc_q <= 1'b0;
      end
    end
  end

endmodule

module zpass_select_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          part_start,
  input logic          busy,
  input logic          out_valid,
  input logic [AW-1:0] out_addr,
  input logic [7:0]    out_mask,
  input logic          pass_done
);

  // R5
  pass_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> !pass_done);

  // R5
  scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_addr > $past(out_addr)));

  // R9
  out_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (busy || pass_done));

  // R4
  out_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != 8'h00));

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    part_start |=> (!busy && !pass_done && !out_valid));

endmodule

bind zpass_select zpass_select_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .part_start(part_start), .busy(busy),
  .out_valid(out_valid), .out_addr(out_addr), .out_mask(out_mask),
  .pass_done(pass_done)
);

// File: tb/tb_zpass_select.sv
module tb_zpass_select;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic part_start = 1'b0, frag_valid = 1'b0, frag_last = 1'b0, frag_opaque = 1'b0;
  logic [AW-1:0] frag_addr = '0;
  logic [15:0] frag_depth = '0;
  logic [7:0] frag_mask = '0, frag_tag = '0;
  logic busy, out_valid, out_opaque, out_under, pass_done, more_passes;
  logic [AW-1:0] out_addr;
  logic [15:0] out_depth;
  logic [7:0] out_mask, out_tag;

  always #10 clk = ~clk;

  zpass_select dut (
    .clk(clk), .rst_n(rst_n), .part_start(part_start), .frag_valid(frag_valid),
    .frag_last(frag_last), .frag_addr(frag_addr), .frag_depth(frag_depth),
    .frag_mask(frag_mask), .frag_opaque(frag_opaque), .frag_tag(frag_tag),
    .busy(busy), .out_valid(out_valid), .out_addr(out_addr), .out_depth(out_depth),
    .out_mask(out_mask), .out_opaque(out_opaque), .out_tag(out_tag),
    .out_under(out_under), .pass_done(pass_done), .more_passes(more_passes)
  );

  typedef struct {
    int a; int d; int m; int o; int t; int u; string req;
  } exp_t;

  exp_t  oq[$];
  bit    pm[$];
  string pr[$];
  int checks = 0, fails = 0, passes_seen = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic exp_out(input int a, input int d, input int m, input int o, input int t, input int u, input string req);
    exp_t e;
    e.a = a; e.d = d; e.m = m; e.o = o; e.t = t; e.u = u; e.req = req;
    oq.push_back(e);
  endtask

  task automatic exp_pass(input bit more, input string req);
    pm.push_back(more);
    pr.push_back(req);
  endtask

  task automatic send(input int a, input int d, input int m, input bit o, input int t, input bit last);
    @(negedge clk);
    frag_valid = 1'b1; frag_addr = AW'(a); frag_depth = 16'(d);
    frag_mask = 8'(m); frag_opaque = o; frag_tag = 8'(t); frag_last = last;
  endtask

  task automatic idle_in;
    @(negedge clk);
    frag_valid = 1'b0; frag_last = 1'b0; part_start = 1'b0;
  endtask

  task automatic tile_start;
    @(negedge clk);
    part_start = 1'b1;
    @(negedge clk);
    part_start = 1'b0;
  endtask

  task automatic wait_passes(input int target);
    while (passes_seen < target) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (oq.size() == 0) begin
          chk(1'b0, "R2", "unexpected output at pixel", int'(out_addr), -1);
        end else begin
          exp_t e;
          e = oq.pop_front();
          chk(int'(out_addr) == e.a, e.req, "addr", int'(out_addr), e.a);
          chk(int'(out_depth) == e.d, e.req, "depth", int'(out_depth), e.d);
          chk(int'(out_mask) == e.m, e.req, "mask", int'(out_mask), e.m);
          chk(int'(out_opaque) == e.o, e.req, "opaque", int'(out_opaque), e.o);
          chk(int'(out_tag) == e.t, e.req, "tag", int'(out_tag), e.t);
          chk(int'(out_under) == e.u, "R6", "under flag", int'(out_under), e.u);
        end
      end
      if (pass_done) begin
        passes_seen++;
        chk(oq.size() == 0, "R5", "outputs missing at pass end", oq.size(), 0);
        oq.delete();
        if (pm.size() == 0) begin
          chk(1'b0, "R7", "unexpected pass report", 1, 0);
        end else begin
          bit mv;
          string rq;
          mv = pm.pop_front();
          rq = pr.pop_front();
          chk(more_passes == mv, rq, "more_passes", int'(more_passes), int'(mv));
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9", "busy in reset", int'(busy), 0);
    chk(out_valid == 1'b0, "R5", "out_valid in reset", int'(out_valid), 0);
    chk(pass_done == 1'b0, "R5", "pass_done in reset", int'(pass_done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R7 R8: nearest-first, opaque full pixel finishes in one pass
    tile_start();
    exp_out(5, 50, 8'hFF, 1, 2, 0, "R2");
    exp_out(9, 20, 8'h0F, 0, 4, 0, "R2");
    exp_pass(1'b1, "R7");
    base = passes_seen;
    send(5, 100, 8'hFF, 1, 1, 0); send(5, 50, 8'hFF, 1, 2, 0);
    send(9, 30, 8'h0F, 0, 3, 0);  send(9, 20, 8'h0F, 0, 4, 1);
    idle_in(); wait_passes(base + 1);
    exp_out(9, 30, 8'h0F, 0, 3, 1, "R8");
    exp_pass(1'b1, "R7");
    send(5, 100, 8'hFF, 1, 1, 0); send(5, 50, 8'hFF, 1, 2, 0);
    send(9, 30, 8'h0F, 0, 3, 0);  send(9, 20, 8'h0F, 0, 4, 1);
    idle_in(); wait_passes(base + 2);
    exp_pass(1'b0, "R7");
    send(5, 100, 8'hFF, 1, 1, 0); send(5, 50, 8'hFF, 1, 2, 0);
    send(9, 30, 8'h0F, 0, 3, 0);  send(9, 20, 8'h0F, 0, 4, 1);
    idle_in(); wait_passes(base + 3);

    // R3: equal depth keeps first arrival; equal to resolved is not reselected
    tile_start();
    base = passes_seen;
    exp_out(3, 40, 8'h03, 0, 7, 0, "R3");
    exp_pass(1'b1, "R3");
    send(3, 40, 8'h03, 0, 7, 0); send(3, 40, 8'h0C, 0, 8, 1);
    idle_in(); wait_passes(base + 1);
    exp_pass(1'b0, "R2");
    send(3, 40, 8'h03, 0, 7, 0); send(3, 40, 8'h0C, 0, 8, 1);
    idle_in(); wait_passes(base + 2);

    // R4: empty mask and hidden fragments are ignored
    tile_start();
    base = passes_seen;
    exp_out(10, 10, 8'h0F, 1, 1, 0, "R4");
    exp_pass(1'b1, "R7");
    send(10, 10, 8'h0F, 1, 1, 0); send(11, 5, 8'h00, 0, 2, 1);
    idle_in(); wait_passes(base + 1);
    exp_out(10, 30, 8'hF0, 0, 4, 1, "R4");
    exp_pass(1'b1, "R4");
    send(10, 20, 8'h0F, 1, 3, 0); send(10, 30, 8'hF0, 0, 4, 1);
    idle_in(); wait_passes(base + 2);
    exp_pass(1'b0, "R4");
    send(10, 20, 8'h0F, 1, 3, 0); send(10, 30, 8'hF0, 0, 4, 1);
    idle_in(); wait_passes(base + 3);

    // R10: eight single-subpixel opaque layers, submitted farthest first
    tile_start();
    base = passes_seen;
    for (int j = 0; j < 8; j++) begin
      exp_out(100, 10 * (j + 1), 1 << j, 1, j, (j > 0) ? 1 : 0, "R10");
      exp_pass(j != 7, "R10");
      for (int k = 7; k >= 0; k--) send(100, 10 * (k + 1), 1 << k, 1'b1, k, k == 0);
      idle_in(); wait_passes(base + j + 1);
    end
    chk(passes_seen - base == 8, "R10", "pass count", passes_seen - base, 8);

    // R9: fragment during scan is ignored
    tile_start();
    base = passes_seen;
    exp_out(20, 50, 8'hFF, 0, 1, 0, "R9");
    exp_pass(1'b1, "R9");
    send(20, 50, 8'hFF, 0, 1, 1);
    idle_in();
    chk(busy == 1'b1, "R9", "busy during scan", int'(busy), 1);
    send(21, 10, 8'hFF, 1, 9, 0);
    idle_in(); wait_passes(base + 1);
    exp_pass(1'b0, "R9");
    send(0, 1, 8'h00, 0, 0, 1);
    idle_in(); wait_passes(base + 2);

    // R1: clear and fragment on the same edge; old resolved depth 50 must not reject 40
    base = passes_seen;
    exp_out(20, 40, 8'h01, 0, 5, 0, "R1");
    exp_pass(1'b1, "R1");
    @(negedge clk);
    part_start = 1'b1; frag_valid = 1'b1; frag_addr = AW'(20); frag_depth = 16'd40;
    frag_mask = 8'h01; frag_opaque = 1'b0; frag_tag = 8'd5; frag_last = 1'b0;
    @(negedge clk);
    part_start = 1'b0; frag_addr = AW'(20); frag_depth = 16'd45; frag_tag = 8'd6;
    frag_last = 1'b1;
    idle_in(); wait_passes(base + 1);

    // R11: clear during scan aborts it
    tile_start();
    base = passes_seen;
    send(400, 5, 8'hFF, 1, 9, 1);
    idle_in();
    repeat (2) @(negedge clk);
    part_start = 1'b1;
    @(negedge clk);
    part_start = 1'b0;
    chk(busy == 1'b0, "R11", "busy after abort", int'(busy), 0);
    repeat (600) @(negedge clk);
    chk(passes_seen == base, "R11", "pass reports after abort", passes_seen - base, 0);
    exp_out(400, 7, 8'h01, 0, 10, 0, "R11");
    exp_pass(1'b1, "R11");
    send(400, 7, 8'h01, 0, 10, 1);
    idle_in(); wait_passes(base + 1);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule